// File: doc/BRIEF.md
# Priority-Based Clock Input Selector

This controller picks one of four reference clock inputs to feed a downstream PLL. Each input reports a loss-of-signal alarm and an out-of-frequency alarm. Mask bits decide, per input and per alarm, whether the alarm counts. A priority value per input orders the candidates, and a mode field chooses a policy. The policy is manual, automatic non-revertive or automatic revertive. When no candidate qualifies in an automatic mode, the block raises a holdover flag and drives no input.

A zero-delay sub-mode has its own select register. When zero-delay is on and its automatic-enable bit is clear, that register names the input directly, and the mode field is bypassed. If zero-delay's automatic-enable bit is set, the mode field governs as usual.

All outputs are registered. A value presented on the inputs is reflected on the outputs after the next rising clock edge.

Top module: `clk_ref_selector`

## Requirements
- R1: In mode 2'b00 (manual), with the zero-delay register path inactive, `sel_idx` takes `man_sel` one clock later and `holdover` is 0, whatever the alarms are.
- R2: An input is eligible only when its priority is non-zero and neither alarm is active unmasked. A mask bit of 1 ignores that input's alarm; a mask bit of 0 lets the alarm disqualify the input.
- R3: Among eligible inputs, the smallest priority value wins. On equal values, the lower input index wins.
- R4: In the automatic modes (2'b01, 2'b10), `man_sel` has no effect on any output.
- R5: In an automatic mode, with no eligible input, `holdover` is 1 one clock later and `sel_idx` keeps its last value.
- R6: In mode 2'b10 (revertive), `sel_idx` is the winning eligible input one clock later, so a better input that becomes eligible preempts the active one.
- R7: In mode 2'b01 (non-revertive), the active input stays selected while it is eligible. When it stops being eligible, or when the block leaves holdover, the winning eligible input is chosen.
- R8: With `zd_en`=1 and `zd_auto_en`=0, `zd_sel` values 0, 1 and 2 select that input directly, clear holdover and override the mode field.
- R9: On that zero-delay register path, `zd_sel`=3 sets `cfg_err` and holds `sel_idx` and `holdover`.
- R10: Mode 2'b11, outside the zero-delay register path, sets `cfg_err` and holds `sel_idx` and `holdover`. In every other case `cfg_err` is 0.
- R11: `switch_pulse` is 1 for exactly the cycles in which `sel_idx` or `holdover` differs from its value in the previous cycle.
- R12: After reset, `sel_idx`=0, `holdover`=1, `switch_pulse`=0 and `cfg_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 00 manual, 01 non-revertive, 10 revertive, 11 reserved |
| man_sel | input | 2 | Manual input index |
| zd_en | input | 1 | Zero-delay sub-mode enable |
| zd_auto_en | input | 1 | Zero-delay automatic-switching enable |
| zd_sel | input | 2 | Zero-delay register select (0..2) |
| prio | input | 12 | Per-input priority, 3 bits each, input i at [3i+2:3i], 0 = never |
| los | input | 4 | Loss-of-signal alarm per input |
| oof | input | 4 | Out-of-frequency alarm per input |
| los_mask | input | 4 | 1 = ignore that input's loss-of-signal alarm |
| oof_mask | input | 4 | 1 = ignore that input's out-of-frequency alarm |
| sel_idx | output | 2 | Selected input index |
| holdover | output | 1 | No input driven |
| switch_pulse | output | 1 | One-cycle strobe on a selection or holdover change |
| cfg_err | output | 1 | Illegal configuration present |

## Verification
Two events can fall in the same cycle. The first case is leaving holdover in non-revertive mode while two inputs of different priority recover together. The bench provokes this by clearing both alarms on one edge, and judges it by requiring the better input and a single strobe. The second case is a reserved mode or an illegal zero-delay select arriving on the same edge as the active input's failure. Here the bench requires that `cfg_err` wins, with the selection and holdover frozen and no strobe. Exhaustive priority and alarm sweeps, together with a free-running mixed sweep, compare every output each cycle against an arithmetic model in the bench.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    MODE_MAN  = 2'b00,
    MODE_NREV = 2'b01,
    MODE_REV  = 2'b10,
    MODE_RSVD = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/csel_qualify.sv
module csel_qualify #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 3
) (
  input  logic [N_IN*PRIO_W-1:0] prio,
  input  logic [N_IN-1:0]        los,
  input  logic [N_IN-1:0]        oof,
  input  logic [N_IN-1:0]        los_mask,
  input  logic [N_IN-1:0]        oof_mask,
  output logic [N_IN-1:0]        elig
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic alarm_hit;
    assign alarm_hit = (los[i] & ~los_mask[i]) | (oof[i] & ~oof_mask[i]);
    assign elig[i]   = ~alarm_hit & (prio[i*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [N_IN*PRIO_W-1:0] prio,
  input  logic [N_IN-1:0]        elig,
  output logic [IDX_W-1:0]       best_idx,
  output logic                   any_elig
);
  logic [PRIO_W-1:0] best_p;
  always_comb begin
    best_idx = '0;
    best_p   = '1;
    any_elig = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig[i] && (!any_elig || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
        best_idx = IDX_W'(i);
        best_p   = prio[i*PRIO_W +: PRIO_W];
        any_elig = 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ref_selector.sv
module clk_ref_selector #(
  parameter int N_IN       = 4,
  parameter int PRIO_W     = 3,
  parameter int ZD_INPUTS  = 3,
  localparam int IDX_W     = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode,
  input  logic [IDX_W-1:0]       man_sel,
  input  logic                   zd_en,
  input  logic                   zd_auto_en,
  input  logic [IDX_W-1:0]       zd_sel,
  input  logic [N_IN*PRIO_W-1:0] prio,
  input  logic [N_IN-1:0]        los,
  input  logic [N_IN-1:0]        oof,
  input  logic [N_IN-1:0]        los_mask,
  input  logic [N_IN-1:0]        oof_mask,
  output logic [IDX_W-1:0]       sel_idx,
  output logic                   holdover,
  output logic                   switch_pulse,
  output logic                   cfg_err
);
  import clksel_pkg::*;

  logic [N_IN-1:0]  elig;
  logic [IDX_W-1:0] best_idx;
  logic             any_elig;

  csel_qualify #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_qual (
    .prio(prio), .los(los), .oof(oof),
    .los_mask(los_mask), .oof_mask(oof_mask), .elig(elig)
  );

  csel_arbiter #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .prio(prio), .elig(elig), .best_idx(best_idx), .any_elig(any_elig)
  );

  sel_mode_e        mode_e;
  logic             zd_reg_path;
  logic [IDX_W-1:0] n_sel;
  logic             n_hold;
  logic             n_err;

  assign mode_e      = sel_mode_e'(mode);
  assign zd_reg_path = zd_en & ~zd_auto_en;

  always_comb begin
    n_sel  = sel_idx;
    n_hold = holdover;
    n_err  = 1'b0;
    if (zd_reg_path) begin
      if (int'(zd_sel) >= ZD_INPUTS) begin
        n_err = 1'b1;
      end else begin
        n_sel  = zd_sel;
        n_hold = 1'b0;
      end
    end else begin
      case (mode_e)
        MODE_MAN: begin
          n_sel  = man_sel;
          n_hold = 1'b0;
        end
        MODE_NREV: begin
          if (!any_elig) begin
            n_hold = 1'b1;
          end else if (holdover || !elig[sel_idx]) begin
            n_sel  = best_idx;
            n_hold = 1'b0;
          end
        end
        MODE_REV: begin
          if (!any_elig) begin
            n_hold = 1'b1;
          end else begin
            n_sel  = best_idx;
            n_hold = 1'b0;
          end
        end
        default: n_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx      <= '0;
      holdover     <= 1'b1;
      switch_pulse <= 1'b0;
      cfg_err      <= 1'b0;
    end else begin
      sel_idx      <= n_sel;
      holdover     <= n_hold;
      switch_pulse <= (n_sel != sel_idx) || (n_hold != holdover);
      cfg_err      <= n_err;
    end
  end
endmodule

// File: rtl/clk_ref_selector_chk.sv
module clk_ref_selector_chk #(
  parameter int N_IN      = 4,
  parameter int PRIO_W    = 3,
  parameter int ZD_INPUTS = 3,
  parameter int IDX_W     = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             mode,
  input logic [IDX_W-1:0]       man_sel,
  input logic                   zd_en,
  input logic                   zd_auto_en,
  input logic [IDX_W-1:0]       zd_sel,
  input logic [N_IN*PRIO_W-1:0] prio,
  input logic [N_IN-1:0]        los,
  input logic [N_IN-1:0]        oof,
  input logic [N_IN-1:0]        los_mask,
  input logic [N_IN-1:0]        oof_mask,
  input logic [IDX_W-1:0]       sel_idx,
  input logic                   holdover,
  input logic                   switch_pulse,
  input logic                   cfg_err
);
  logic [N_IN-1:0] ok_in;
  logic            zreg;
  logic            past_ok;

  for (genvar i = 0; i < N_IN; i++) begin : g_ok
    assign ok_in[i] = !(los[i] && !los_mask[i]) && !(oof[i] && !oof_mask[i])
                      && (prio[i*PRIO_W +: PRIO_W] != '0);
  end
  assign zreg = zd_en && !zd_auto_en;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (sel_idx == '0 && holdover && !switch_pulse && !cfg_err));

  a_r1_manual_follows: assert property (@(posedge clk) disable iff (rst)
    (!zreg && mode == 2'b00) |=> (sel_idx == $past(man_sel) && !holdover));

  a_r5_holdover_when_none: assert property (@(posedge clk) disable iff (rst)
    (!zreg && (mode == 2'b01 || mode == 2'b10) && ok_in == '0)
      |=> (holdover && $stable(sel_idx)));

  a_r7_nonrev_keeps: assert property (@(posedge clk) disable iff (rst)
    (!zreg && mode == 2'b01 && !holdover && ok_in[sel_idx])
      |=> ($stable(sel_idx) && !holdover));

  a_r8_zd_select: assert property (@(posedge clk) disable iff (rst)
    (zreg && int'(zd_sel) < ZD_INPUTS) |=> (sel_idx == $past(zd_sel) && !holdover && !cfg_err));

  a_r9_zd_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    (zreg && int'(zd_sel) >= ZD_INPUTS) |=> (cfg_err && $stable(sel_idx) && $stable(holdover)));

  a_r10_reserved_holds: assert property (@(posedge clk) disable iff (rst)
    (!zreg && mode == 2'b11) |=> (cfg_err && $stable(sel_idx) && $stable(holdover)));

  a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (switch_pulse == ((sel_idx != $past(sel_idx)) || (holdover != $past(holdover)))));
endmodule

bind clk_ref_selector clk_ref_selector_chk #(
  .N_IN(N_IN), .PRIO_W(PRIO_W), .ZD_INPUTS(ZD_INPUTS), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_clk_ref_selector.sv
module tb_clk_ref_selector;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic [1:0] man_sel;
  logic       zd_en, zd_auto_en;
  logic [1:0] zd_sel;
  logic [11:0] prio;
  logic [3:0] los, oof, los_mask, oof_mask;
  logic [1:0] sel_idx;
  logic       holdover, switch_pulse, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] m_sel;
  logic       m_hold, m_err, m_pulse;

  always #2.5 clk = ~clk;

  clk_ref_selector dut (
    .clk(clk), .rst(rst), .mode(mode), .man_sel(man_sel),
    .zd_en(zd_en), .zd_auto_en(zd_auto_en), .zd_sel(zd_sel), .prio(prio),
    .los(los), .oof(oof), .los_mask(los_mask), .oof_mask(oof_mask),
    .sel_idx(sel_idx), .holdover(holdover), .switch_pulse(switch_pulse),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: next state from the requirements.
  task automatic model_next();
    logic [3:0] ok;
    logic [1:0] best;
    int bp;
    logic any;
    logic [1:0] ns;
    logic nh, ne;
    ns = m_sel; nh = m_hold; ne = 1'b0;
    any = 1'b0; best = 2'd0; bp = 99;
    for (int i = 0; i < 4; i++) begin
      ok[i] = !(los[i] && !los_mask[i]) && !(oof[i] && !oof_mask[i]) && (prio[i*3 +: 3] != 0);
      if (ok[i] && int'(prio[i*3 +: 3]) < bp) begin
        bp = int'(prio[i*3 +: 3]); best = 2'(i); any = 1'b1;
      end
    end
    if (zd_en && !zd_auto_en) begin
      if (zd_sel == 2'd3) ne = 1'b1;
      else begin ns = zd_sel; nh = 1'b0; end
    end else if (mode == 2'b00) begin
      ns = man_sel; nh = 1'b0;
    end else if (mode == 2'b11) begin
      ne = 1'b1;
    end else if (!any) begin
      nh = 1'b1;
    end else if (mode == 2'b10 || m_hold || !ok[m_sel]) begin
      ns = best; nh = 1'b0;
    end
    m_pulse = (ns != m_sel) || (nh != m_hold);
    m_sel = ns; m_hold = nh; m_err = ne;
  endtask

  // Inputs are already set; clock once and compare all outputs.
  task automatic step(input string tag);
    model_next();
    @(posedge clk);
    #1;
    chk(tag, sel_idx, m_sel);
    chk(tag, holdover, m_hold);
    chk(tag, cfg_err, m_err);
    chk("R11", switch_pulse, m_pulse);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode = 2'b00; man_sel = 2'd2; zd_en = 1'b0; zd_auto_en = 1'b0;
    zd_sel = 2'd0; prio = {3'd4, 3'd3, 3'd2, 3'd1};
    los = '0; oof = '0; los_mask = '0; oof_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", sel_idx, 0); chk("R12", holdover, 1);
    chk("R12", switch_pulse, 0); chk("R12", cfg_err, 0);
    m_sel = 2'd0; m_hold = 1'b1; m_err = 1'b0;
    rst = 1'b0;

    // R1: manual follows man_sel even with all alarms active
    los = '1; oof = '1;
    for (int k = 0; k < 4; k++) begin man_sel = 2'(3 - k); step("R1"); end
    step("R1");  // no change -> pulse must be 0
    chk("R11", switch_pulse, 0);

    // R6 / R3 / R5: exhaustive priorities x loss pattern, revertive
    mode = 2'b10; oof = '0; oof_mask = '0; los_mask = '0;
    for (int p = 0; p < 625; p++) begin
      prio = {3'(p / 125 % 5), 3'(p / 25 % 5), 3'(p / 5 % 5), 3'(p % 5)};
      for (int a = 0; a < 16; a++) begin
        los = 4'(a);
        man_sel = 2'(a ^ p);  // R4: must not matter
        step("R6");
      end
    end

    // R2: mask sweep with fixed distinct priorities, alternating policies
    prio = {3'd4, 3'd3, 3'd2, 3'd1};
    for (int v = 0; v < 4096; v++) begin
      los = 4'(v); oof = 4'(v >> 4); los_mask = 4'(v >> 8);
      oof_mask = los_mask ^ 4'b0101;
      mode = (v % 3 == 0) ? 2'b01 : 2'b10;
      step("R2");
    end

    // R7: non-revertive holds, then leaves holdover with two inputs returning together
    mode = 2'b01; los_mask = '0; oof_mask = '0; oof = '0;
    los = 4'b1110; step("R7");               // only IN0 -> sel 0
    chk("R7", sel_idx, 0);
    los = 4'b1100; prio = {3'd4, 3'd3, 3'd1, 3'd2}; step("R7");  // IN1 better, keep IN0
    chk("R7", sel_idx, 0);
    los = 4'b1111; step("R5");
    chk("R5", holdover, 1); chk("R5", sel_idx, 0);
    los = 4'b1001; step("R7");               // IN1 (p1) and IN2 (p3) return together
    chk("R7", sel_idx, 1); chk("R11", switch_pulse, 1);
    step("R7"); chk("R11", switch_pulse, 0);
    man_sel = 2'd3; step("R4"); chk("R4", sel_idx, 1);

    // R10: reserved mode on the same edge the active input fails
    mode = 2'b11; los = 4'b1111; step("R10");
    chk("R10", cfg_err, 1); chk("R10", sel_idx, 1); chk("R10", holdover, 0);
    chk("R11", switch_pulse, 0);

    // R8 / R9: zero-delay register path
    zd_en = 1'b1; zd_auto_en = 1'b0;
    for (int z = 0; z < 4; z++) begin zd_sel = 2'(z); step(z == 3 ? "R9" : "R8"); end
    chk("R9", cfg_err, 1); chk("R9", sel_idx, 2);
    zd_auto_en = 1'b1; mode = 2'b10; los = 4'b0111; step("R8");
    chk("R8", sel_idx, 3);

    // Mixed free-running sweep
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      r = $urandom;
      mode = r[1:0]; man_sel = r[3:2]; zd_en = (r[7:4] == 0); zd_auto_en = r[8];
      zd_sel = r[10:9]; los = r[14:11] & r[18:15]; oof = r[22:19] & r[26:23];
      los_mask = {r[27], r[28], 2'b00}; oof_mask = {2'b00, r[29], r[30]};
      if (r[31]) prio = 12'($urandom);
      step("R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule